// File: doc/BRIEF.md
# ADC Conversion Result and Channel Control Registers

This block is a byte-wide register window that links a 12-bit analog-to-digital conversion engine to a host processor. Each time the converter signals a finished conversion, the block stores the 12-bit result. The host reads the result as two bytes. The upper byte also carries an active-low ready indicator, which goes low when a new result is captured. The indicator returns high as a side effect of the host reading the lower byte. This lets a polling loop wait for the flag to go low and then fetch the lower byte last, which re-arms the flag.

The host writes a control byte to pick the converter's input channel and its single-ended/differential mode. A new selection does not reach the converter straight away. It is held as a pending value and is applied at the next conversion-done pulse, so a conversion in progress is never disturbed. If several writes arrive before that pulse, only the last one is kept.

All bus traffic is synchronous to one clock. Read data is registered and appears one cycle after the read strobe. A read that hits no readable register returns zero.

Top module: `adc_host_regs`

## Requirements
- R1: After synchronous reset, the stored result is 0, the ready flag is 1, and both the channel output and the mode output are 0. A read of offset 5 then returns 0x10.
- R2: A cycle with `conv_done` high stores `conv_result` and drives the ready flag to 0 at that clock edge.
- R3: A read of offset 4 returns result bits 7:0. A read of offset 5 returns result bits 11:8 in bits 3:0, the active-low ready flag in bit 4, and zeros in bits 7:5.
- R4: A rising edge of `bus_rd` at offset 4 sets the ready flag to 1. Holding `bus_rd` high for more cycles does not set it again.
- R5: When `conv_done` coincides with the rising edge of a read at offset 4, the new result is stored and the flag stays 0. The read itself returns the low byte of the previous result.
- R6: Writes to offsets 4 and 5 change neither the stored result nor the flag.
- R7: A write to offset 10 takes the channel from data bits 3:0 and the mode from data bits 5:4, and ignores bits 7:6. The outputs `chan_sel` and `mode_sel` change only in a cycle that follows a `conv_done` pulse.
- R8: At a `conv_done` pulse, the most recently written pending channel and mode are applied to the outputs. A later pulse with no new write leaves the outputs unchanged.
- R9: Reads of offset 10 and of any offset other than 4 and 5 return 0x00.
- R10: `bus_rdata` holds the value selected by the read one cycle after `bus_rd` is sampled high, and is 0x00 in the cycle after `bus_rd` is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| conv_done | input | 1 | One-cycle conversion finished pulse |
| conv_result | input | 12 | Conversion result, valid with `conv_done` |
| chan_sel | output | 4 | Channel applied to the converter |
| mode_sel | output | 2 | Input mode applied to the converter |

## Verification
The checks assume that `conv_done` and `conv_result` are driven from the same clock, and that `bus_rd` and `bus_wr` are not raised together in one cycle. They also assume that reset is held for at least two edges, so that the registers hold defined values before any check looks at them. The stimulus changes every input on the falling clock edge, never issues a read and a write together, and holds reset for four cycles. It raises `conv_done` for exactly one cycle, except in the deliberate overlap with a held low-byte read.

// File: rtl/adc_regs_pkg.sv
package adc_regs_pkg;
   // Register region selected by a bus offset
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_LO   = 2'd1,
      SEL_HI   = 2'd2,
      SEL_CTL  = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/adc_addr_dec.sv
module adc_addr_dec
   import adc_regs_pkg::*;
#(
   parameter int ADDR_W  = 4,
   parameter int OFS_LO  = 4,
   parameter int OFS_HI  = 5,
   parameter int OFS_CTL = 10
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);
   localparam int SPAN = 1 << ADDR_W;

   if (OFS_LO >= SPAN || OFS_HI >= SPAN || OFS_CTL >= SPAN) begin : g_ofs_range
      $error("adc_addr_dec: an offset does not fit in ADDR_W");
   end
   if (OFS_LO == OFS_HI || OFS_LO == OFS_CTL || OFS_HI == OFS_CTL) begin : g_ofs_unique
      $error("adc_addr_dec: offsets must be distinct");
   end

   localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(OFS_LO);
   localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(OFS_HI);
   localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFS_CTL);

   always_comb begin
      if (addr == A_LO)       sel = SEL_LO;
      else if (addr == A_HI)  sel = SEL_HI;
      else if (addr == A_CTL) sel = SEL_CTL;
      else                    sel = SEL_NONE;
   end
endmodule

// File: rtl/adc_result_hold.sv
module adc_result_hold #(
   parameter int RES_W = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             done,
   input  logic [RES_W-1:0] res_in,
   input  logic             clr_rdy,
   output logic [RES_W-1:0] res_q,
   output logic             rdy_n
);
   if (RES_W < 2) begin : g_res_chk
      $error("adc_result_hold: RES_W too small");
   end

   // A new result outranks the re-arm from a low-byte read
   always_ff @(posedge clk) begin
      if (rst) begin
         res_q <= '0;
         rdy_n <= 1'b1;
      end else if (done) begin
         res_q <= res_in;
         rdy_n <= 1'b0;
      end else if (clr_rdy) begin
         rdy_n <= 1'b1;
      end
   end
endmodule

// File: rtl/adc_chan_ctl.sv
module adc_chan_ctl #(
   parameter int CH_W   = 4,
   parameter int MODE_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_ctl,
   input  logic [CH_W-1:0]   wr_ch,
   input  logic [MODE_W-1:0] wr_md,
   input  logic              done,
   output logic [CH_W-1:0]   chan,
   output logic [MODE_W-1:0] mode
);
   if (CH_W < 1 || MODE_W < 1) begin : g_w_chk
      $error("adc_chan_ctl: widths must be positive");
   end

   logic              pend_v;
   logic [CH_W-1:0]   pend_ch;
   logic [MODE_W-1:0] pend_md;

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_v  <= 1'b0;
         pend_ch <= '0;
         pend_md <= '0;
         chan    <= '0;
         mode    <= '0;
      end else begin
         if (done && pend_v) begin
            chan <= pend_ch;
            mode <= pend_md;
         end
         if (wr_ctl) begin
            pend_ch <= wr_ch;
            pend_md <= wr_md;
            pend_v  <= 1'b1;
         end else if (done) begin
            pend_v  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/adc_host_regs.sv
module adc_host_regs
   import adc_regs_pkg::*;
#(
   parameter int ADDR_W  = 4,
   parameter int DATA_W  = 8,
   parameter int RES_W   = 12,
   parameter int CH_W    = 4,
   parameter int MODE_W  = 2,
   parameter int OFS_LO  = 4,
   parameter int OFS_HI  = 5,
   parameter int OFS_CTL = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              conv_done,
   input  logic [RES_W-1:0]  conv_result,
   output logic [CH_W-1:0]   chan_sel,
   output logic [MODE_W-1:0] mode_sel
);
   localparam int UP_W  = RES_W - DATA_W;
   localparam int PAD_W = DATA_W - UP_W - 1;

   if (UP_W < 1 || PAD_W < 0) begin : g_res_fit
      $error("adc_host_regs: result must span two bytes with room for the flag");
   end
   if (CH_W + MODE_W > DATA_W) begin : g_ctl_fit
      $error("adc_host_regs: control fields exceed the data width");
   end

   reg_sel_e          sel;
   logic              rd_q;
   logic              clr_rdy;
   logic              wr_ctl;
   logic [RES_W-1:0]  res_q;
   logic              rdy_n;
   logic [DATA_W-1:0] lo_byte;
   logic [DATA_W-1:0] hi_byte;

   adc_addr_dec #(
      .ADDR_W (ADDR_W),
      .OFS_LO (OFS_LO),
      .OFS_HI (OFS_HI),
      .OFS_CTL(OFS_CTL)
   ) i_dec (
      .addr(bus_addr),
      .sel (sel)
   );

   always_ff @(posedge clk) begin
      if (rst) rd_q <= 1'b0;
      else     rd_q <= bus_rd;
   end

   assign clr_rdy = bus_rd && !rd_q && (sel == SEL_LO);
   assign wr_ctl  = bus_wr && (sel == SEL_CTL);

   adc_result_hold #(.RES_W(RES_W)) i_hold (
      .clk    (clk),
      .rst    (rst),
      .done   (conv_done),
      .res_in (conv_result),
      .clr_rdy(clr_rdy),
      .res_q  (res_q),
      .rdy_n  (rdy_n)
   );

   adc_chan_ctl #(.CH_W(CH_W), .MODE_W(MODE_W)) i_ctl (
      .clk   (clk),
      .rst   (rst),
      .wr_ctl(wr_ctl),
      .wr_ch (bus_wdata[CH_W-1:0]),
      .wr_md (bus_wdata[CH_W+MODE_W-1:CH_W]),
      .done  (conv_done),
      .chan  (chan_sel),
      .mode  (mode_sel)
   );

   assign lo_byte = res_q[DATA_W-1:0];

   if (PAD_W > 0) begin : g_hi_pad
      assign hi_byte = {{PAD_W{1'b0}}, rdy_n, res_q[RES_W-1:DATA_W]};
   end else begin : g_hi_full
      assign hi_byte = {rdy_n, res_q[RES_W-1:DATA_W]};
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         bus_rdata <= '0;
      end else if (bus_rd) begin
         case (sel)
            SEL_LO:  bus_rdata <= lo_byte;
            SEL_HI:  bus_rdata <= hi_byte;
            default: bus_rdata <= '0;
         endcase
      end else begin
         bus_rdata <= '0;
      end
   end
endmodule

// File: rtl/adc_host_regs_chk.sv
module adc_host_regs_chk #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8,
   parameter int CH_W   = 4,
   parameter int MODE_W = 2,
   parameter int OFS_LO = 4,
   parameter int OFS_HI = 5
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_rd,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              conv_done,
   input logic [CH_W-1:0]   chan_sel,
   input logic [MODE_W-1:0] mode_sel,
   input logic              rdy_n
);
   logic rd_prev;
   always_ff @(posedge clk) begin
      if (rst) rd_prev <= 1'b0;
      else     rd_prev <= bus_rd;
   end

   // R1
   reset_state_chk: assert property (@(posedge clk)
      rst |=> (rdy_n && chan_sel == '0 && mode_sel == '0));

   // R2
   done_arms_chk: assert property (@(posedge clk) disable iff (rst)
      conv_done |=> !rdy_n);

   // R4
   lo_read_rearm_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && !rd_prev && bus_addr == ADDR_W'(OFS_LO) && !conv_done) |=> rdy_n);

   // R7
   chan_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !conv_done |=> ($stable(chan_sel) && $stable(mode_sel)));

   // R3
   hi_pad_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && bus_addr == ADDR_W'(OFS_HI)) |=> (bus_rdata[DATA_W-1:DATA_W-3] == 3'b000));

   // R9
   other_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && bus_addr != ADDR_W'(OFS_LO) && bus_addr != ADDR_W'(OFS_HI)) |=> bus_rdata == '0);

   // R10
   idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
      !bus_rd |=> bus_rdata == '0);
endmodule

bind adc_host_regs adc_host_regs_chk #(
   .ADDR_W(ADDR_W),
   .DATA_W(DATA_W),
   .CH_W  (CH_W),
   .MODE_W(MODE_W),
   .OFS_LO(OFS_LO),
   .OFS_HI(OFS_HI)
) i_chk (
   .clk      (clk),
   .rst      (rst),
   .bus_addr (bus_addr),
   .bus_rd   (bus_rd),
   .bus_rdata(bus_rdata),
   .conv_done(conv_done),
   .chan_sel (chan_sel),
   .mode_sel (mode_sel),
   .rdy_n    (rdy_n)
);

// File: tb/test_adc_host_regs.sv
module test_adc_host_regs;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        conv_done = 1'b0;
   logic [11:0] conv_result = '0;
   logic [3:0]  chan_sel;
   logic [1:0]  mode_sel;

   int checks = 0;
   int failures = 0;
   logic [7:0] q_exp[$];
   string      q_tag[$];
   logic       rd_seen = 1'b0;

   always #10 clk = ~clk;

   adc_host_regs i_adc_host_regs (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_done(conv_done),
      .conv_result(conv_result), .chan_sel(chan_sel), .mode_sel(mode_sel)
   );

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // monitor: a read sampled at a rising edge is compared at the next falling edge
   always @(posedge clk) rd_seen <= bus_rd;
   always @(negedge clk) begin
      if (rd_seen) begin
         if (q_exp.size() == 0) begin
            chk(1'b0, "R10 unexpected read data", bus_rdata, 0);
         end else begin
            logic [7:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            chk(bus_rdata == e, t, bus_rdata, e);
         end
      end
   end

   task automatic push(input logic [7:0] e, input string tag);
      q_exp.push_back(e);
      q_tag.push_back(tag);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1; push(e, tag);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic done(input logic [11:0] r);
      @(negedge clk);
      conv_result = r; conv_done = 1'b1;
      @(negedge clk);
      conv_done = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      idle(4);
      rst = 1'b0;
      idle(1);
      // R1 reset state
      chk(chan_sel == 0, "R1 chan after reset", chan_sel, 0);
      chk(mode_sel == 0, "R1 mode after reset", mode_sel, 0);
      chk(bus_rdata == 0, "R10 idle rdata", bus_rdata, 0);
      rd(4'd5, 8'h10, "R1 high byte after reset");
      rd(4'd4, 8'h00, "R1 low byte after reset");

      // R2 / R3 / R4
      done(12'hA5C);
      rd(4'd5, 8'h0A, "R2 flag low after done");
      rd(4'd4, 8'h5C, "R3 low byte");
      rd(4'd5, 8'h1A, "R4 flag re-armed by low read");

      // R6 writes to data offsets ignored
      wr(4'd4, 8'hFF);
      wr(4'd5, 8'hFF);
      rd(4'd4, 8'h5C, "R6 low byte after writes");
      rd(4'd5, 8'h1A, "R6 high byte after writes");

      // R7 / R8 deferred channel change, last write wins, bits 7:6 ignored
      wr(4'd10, 8'hC7);
      wr(4'd10, 8'hE9);
      idle(2);
      chk(chan_sel == 0, "R7 chan held before done", chan_sel, 0);
      chk(mode_sel == 0, "R7 mode held before done", mode_sel, 0);
      done(12'h3F1);
      chk(chan_sel == 9, "R8 chan applied", chan_sel, 9);
      chk(mode_sel == 2, "R8 mode applied", mode_sel, 2);
      done(12'h777);
      chk(chan_sel == 9, "R8 chan kept without write", chan_sel, 9);
      chk(mode_sel == 2, "R8 mode kept without write", mode_sel, 2);

      // R9 zero reads
      rd(4'd10, 8'h00, "R9 control offset reads zero");
      rd(4'd0, 8'h00, "R9 offset 0 reads zero");
      rd(4'd15, 8'h00, "R9 offset 15 reads zero");

      // R5 done coincides with low read
      @(negedge clk);
      bus_addr = 4'd4; bus_rd = 1'b1; conv_result = 12'h8B4; conv_done = 1'b1;
      push(8'h77, "R5 read returns previous low byte");
      @(negedge clk);
      bus_rd = 1'b0; conv_done = 1'b0;
      rd(4'd5, 8'h08, "R5 flag stays low");

      // R4 held read re-arms only once
      rd(4'd4, 8'hB4, "R4 low read");
      @(negedge clk);
      bus_addr = 4'd4; bus_rd = 1'b1; push(8'hB4, "R4 held read cycle 1");
      @(negedge clk);
      conv_result = 12'h123; conv_done = 1'b1; push(8'hB4, "R4 held read cycle 2");
      @(negedge clk);
      conv_done = 1'b0; push(8'h23, "R4 held read cycle 3");
      @(negedge clk);
      bus_rd = 1'b0;
      rd(4'd5, 8'h01, "R4 no second re-arm while held");

      idle(3);
      chk(bus_rdata == 0, "R10 rdata zero when idle", bus_rdata, 0);
      chk(q_exp.size() == 0, "R10 all reads answered", q_exp.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule